// File: doc/BRIEF.md
# Serial Register Slave with Pipelined Read-Back

This block is a synchronous-serial slave that gives a host controller access to a small bank of 8-bit configuration registers. The host drives three lines: a serial clock, a serial data input and an active-low chip select. While chip select is low, the host shifts in one 16-bit frame. The frame carries a 7-bit register address, then a direction bit, then an 8-bit data byte. The address and the data byte are each sent most significant bit first.

The serial lines are resynchronised into the core clock domain. The block then detects their edges and decodes the frame. A write frame updates the selected register when chip select rises. On that edge the block also sends the core a one-cycle write strobe with the address and data.

Reads are pipelined. A read frame only records the address. In the following frame the data output line replays the previous frame's address and direction bit, followed by the contents of the register that was named. During every frame the data output line plays back the last complete frame. Its driver is enabled only while a frame is open.

Top module: `mw_reg_slave`

## Requirements
- R1: A frame is 16 serial clocks. The first seven bits are the address (bit 6 first), the eighth bit is the direction bit, and the last eight bits are the data byte (bit 7 first).
- R2: A complete frame whose direction bit is 1 writes its data byte into the addressed register. At the end of that frame `wr_stb` is high for exactly one core cycle, with `wr_addr` and `wr_data` equal to the frame's address and data.
- R3: Input bits are taken on rising edges of `mw_sclk`. `mw_sdo` changes only after a falling edge of `mw_sclk`, so its value is stable while `mw_sclk` is high.
- R4: A complete frame whose direction bit is 0 writes nothing. The frame after it carries the addressed register's value in its last eight output bits. Repeated reads of the same address return the value in every frame.
- R5: `mw_sdo_oe` is 1 while `mw_csn` is low and 0 once `mw_csn` has returned high.
- R6: During a frame, `mw_sdo` presents a 16-bit word, most significant bit first. The upper eight bits are the address and direction bit of the last complete frame. The lower eight bits are that frame's data byte if it was a write, or the addressed register's value if it was a read.
- R7: A frame that ends after any number of clocks other than 16 is discarded. It writes nothing, produces no strobe, and does not replace the last complete frame.
- R8: Only addresses 0 to 15 select registers. A write to a higher address changes no register and gives no strobe. A read of a higher address returns 00h.
- R9: After reset all registers hold 00h, `wr_stb` and `mw_sdo_oe` are 0, and the first frame plays back the all-zero word.
- R10: Raising `mw_csn` clears the bit count, so the frame after a discarded frame is decoded from its own first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mw_sclk | input | 1 | Serial clock from host |
| mw_sdi | input | 1 | Serial data from host |
| mw_csn | input | 1 | Active-low frame select |
| mw_sdo | output | 1 | Serial data to host |
| mw_sdo_oe | output | 1 | Enable for the external tristate buffer on `mw_sdo` |
| wr_stb | output | 1 | One-cycle register write strobe to the core |
| wr_addr | output | 7 | Address of the register being written |
| wr_data | output | 8 | Data being written |

## Verification
The bench builds the block with its defaults: a 7-bit address, 16 registers and a two-stage synchroniser. Because the address is wider than the register index, addresses 16 to 127 can be driven, and the bench uses them to show that a write to 12h does not alias onto register 2 and that a read of 7Fh returns zero. Each half period of the serial clock lasts eight core cycles, which leaves room for the synchroniser delay. Over that span, output bits taken just before each rising edge can be compared with the same bits taken just before the following falling edge.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int MW_ADDR_W  = 7;
  localparam int MW_DATA_W  = 8;
  localparam int MW_FRAME_W = MW_ADDR_W + 1 + MW_DATA_W;

  typedef struct packed {
    logic [MW_ADDR_W-1:0] addr;
    logic                 rw;
    logic [MW_DATA_W-1:0] data;
  } mw_frame_t;

  function automatic logic addr_hits(input logic [MW_ADDR_W-1:0] a, input int nregs);
    return (int'(a) < nregs);
  endfunction

  function automatic mw_frame_t echo_word(input mw_frame_t last, input logic [MW_DATA_W-1:0] rd);
    mw_frame_t w;
    w      = last;
    w.data = last.rw ? last.data : rd;
    return w;
  endfunction
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= RST_VAL;
      else if (s == 0) stg[s] <= d;
      else stg[s] <= stg[(s > 0) ? s - 1 : 0];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/mw_shifter.sv
module mw_shifter #(
  parameter int FRAME_W = 16,
  localparam int CNT_W  = $clog2(FRAME_W + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_s,
  input  logic               sdi_s,
  input  logic               csn_s,
  input  logic [FRAME_W-1:0] tx_word,
  output logic [FRAME_W-1:0] rx_word,
  output logic               sdo,
  output logic               sdo_oe,
  output logic               frame_start,
  output logic               frame_end,
  output logic               frame_ok,
  output logic               sclk_fall,
  output logic [CNT_W-1:0]   bit_cnt
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

  logic sclk_d, csn_d;
  logic sclk_rise;
  logic [FRAME_W-1:0] out_sr;

  assign frame_start = csn_d & ~csn_s;
  assign frame_end   = ~csn_d & csn_s;
  assign sclk_rise   = ~sclk_d & sclk_s & ~csn_s;
  assign sclk_fall   = sclk_d & ~sclk_s & ~csn_s;
  assign frame_ok    = frame_end && (bit_cnt == CNT_FULL);
  assign sdo         = out_sr[FRAME_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      csn_d  <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      csn_d  <= csn_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      rx_word <= '0;
    end else if (csn_s || frame_start) begin
      bit_cnt <= '0;
    end else if (sclk_rise) begin
      rx_word <= {rx_word[FRAME_W-2:0], sdi_s};
      if (bit_cnt != CNT_OVER) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_sr <= '0;
      sdo_oe <= 1'b0;
    end else if (frame_start) begin
      out_sr <= tx_word;
      sdo_oe <= 1'b1;
    end else if (frame_end) begin
      sdo_oe <= 1'b0;
    end else if (sclk_fall) begin
      out_sr <= {out_sr[FRAME_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/mw_regfile.sv
module mw_regfile #(
  parameter int NUM_REGS = 16,
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 8,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[g] <= '0;
      else if (we && (int'(waddr) == g)) mem[g] <= wdata;
    end
  end

  assign rdata = (int'(raddr) < NUM_REGS) ? mem[raddr[IDX_W-1:0]] : '0;
endmodule

// File: rtl/mw_reg_slave.sv
module mw_reg_slave
  import mw_pkg::*;
#(
  parameter int NUM_REGS    = 16,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = MW_ADDR_W,
  localparam int DATA_W     = MW_DATA_W,
  localparam int FRAME_W    = MW_FRAME_W,
  localparam int CNT_W      = $clog2(FRAME_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mw_sclk,
  input  logic              mw_sdi,
  input  logic              mw_csn,
  output logic              mw_sdo,
  output logic              mw_sdo_oe,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  logic [2:0] pins_s;
  logic sclk_s, sdi_s, csn_s;
  logic frame_start, frame_end, frame_ok, sclk_fall;
  logic [CNT_W-1:0] bit_cnt;
  mw_frame_t rx_frame, last_frame, tx_frame;
  logic [DATA_W-1:0] rd_data;
  logic wr_hit;

  mw_sync #(.STAGES(SYNC_STAGES), .WIDTH(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({mw_csn, mw_sdi, mw_sclk}),
    .q(pins_s)
  );
  assign {csn_s, sdi_s, sclk_s} = pins_s;

  mw_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(sclk_s), .sdi_s(sdi_s), .csn_s(csn_s),
    .tx_word(tx_frame),
    .rx_word(rx_frame),
    .sdo(mw_sdo), .sdo_oe(mw_sdo_oe),
    .frame_start(frame_start), .frame_end(frame_end),
    .frame_ok(frame_ok), .sclk_fall(sclk_fall),
    .bit_cnt(bit_cnt)
  );

  assign wr_hit = rx_frame.rw && addr_hits(rx_frame.addr, NUM_REGS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_frame <= '0;
      wr_stb     <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (frame_ok) begin
        last_frame <= rx_frame;
        wr_stb     <= wr_hit;
        wr_addr    <= rx_frame.addr;
        wr_data    <= rx_frame.data;
      end
    end
  end

  mw_regfile #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .we(wr_stb), .waddr(wr_addr), .wdata(wr_data),
    .raddr(last_frame.addr), .rdata(rd_data)
  );

  assign tx_frame = echo_word(last_frame, rd_data);
endmodule

// File: rtl/mw_reg_slave_chk.sv
module mw_reg_slave_chk #(
  parameter int NUM_REGS = 16,
  parameter int FRAME_W  = 16,
  parameter int ADDR_W   = 7,
  parameter int CNT_W    = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mw_sdo,
  input logic              mw_sdo_oe,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              frame_end,
  input logic              sclk_fall,
  input logic [CNT_W-1:0]  bit_cnt
);
  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  assert_strobe_full_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> ($past(bit_cnt) == CNT_W'(FRAME_W)));

  assert_strobe_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (int'(wr_addr) < NUM_REGS));

  assert_oe_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !mw_sdo_oe);

  assert_sdo_moves_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_sdo_oe && $past(mw_sdo_oe) && (mw_sdo != $past(mw_sdo))) |-> $past(sclk_fall));

  assert_count_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
    int'(bit_cnt) <= FRAME_W + 1);
endmodule

bind mw_reg_slave mw_reg_slave_chk #(
  .NUM_REGS(NUM_REGS), .FRAME_W(FRAME_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mw_sdo(mw_sdo), .mw_sdo_oe(mw_sdo_oe),
  .wr_stb(wr_stb), .wr_addr(wr_addr), .frame_end(frame_end),
  .sclk_fall(sclk_fall), .bit_cnt(bit_cnt)
);

// File: tb/mw_reg_slave_tb.sv
module mw_reg_slave_tb;
  localparam int HP = 8;
  localparam int NV = 13;
  // each entry: {frame sent, word expected on mw_sdo}
  localparam logic [31:0] VEC [NV] = '{
    {7'h03, 1'b1, 8'h5A, 16'h0000},  // R9 first frame replays zero
    {7'h0F, 1'b1, 8'hC3, 16'h075A},  // R6 write echoed
    {7'h03, 1'b0, 8'h00, 16'h1FC3},
    {7'h03, 1'b0, 8'h00, 16'h065A},  // R4 read data
    {7'h0F, 1'b0, 8'h00, 16'h065A},  // R4 repeated read
    {7'h12, 1'b1, 8'hAB, 16'h1EC3},  // R4 reg 0F
    {7'h12, 1'b0, 8'h00, 16'h25AB},  // R8 out-of-range write echoed
    {7'h02, 1'b0, 8'h00, 16'h2400},  // R8 read of 12h is 00
    {7'h00, 1'b1, 8'hFF, 16'h0400},  // R8 reg 2 untouched
    {7'h00, 1'b0, 8'h00, 16'h01FF},
    {7'h7F, 1'b0, 8'h00, 16'h00FF},  // R1 reg 0
    {7'h01, 1'b1, 8'h81, 16'hFE00},  // R8 read of 7Fh
    {7'h01, 1'b0, 8'h00, 16'h0381}   // R2 write echoed
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mw_sclk = 1'b0, mw_sdi = 1'b0, mw_csn = 1'b1;
  logic mw_sdo, mw_sdo_oe, wr_stb;
  logic [6:0] wr_addr;
  logic [7:0] wr_data;

  int n_run = 0, n_fail = 0, n_stb = 0;
  logic [6:0] last_a = '0;
  logic [7:0] last_d = '0;
  logic [15:0] got;
  logic stable_ok;
  logic oe_in_frame;

  always #4 clk = ~clk;

  mw_reg_slave u_dut (
    .clk(clk), .rst_n(rst_n), .mw_sclk(mw_sclk), .mw_sdi(mw_sdi), .mw_csn(mw_csn),
    .mw_sdo(mw_sdo), .mw_sdo_oe(mw_sdo_oe), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always @(posedge clk) if (wr_stb) begin
    n_stb  <= n_stb + 1;
    last_a <= wr_addr;
    last_d <= wr_data;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [15:0] word, input int nclk);
    got = '0;
    stable_ok = 1'b1;
    mw_csn = 1'b0;
    for (int i = 0; i < nclk; i++) begin
      mw_sdi = word[15-i];
      repeat (HP) @(negedge clk);
      if (i == 0) oe_in_frame = mw_sdo_oe;
      got[15-i] = mw_sdo;
      mw_sclk = 1'b1;
      repeat (HP) @(negedge clk);
      if (mw_sdo !== got[15-i]) stable_ok = 1'b0;
      mw_sclk = 1'b0;
    end
    repeat (HP) @(negedge clk);
    mw_csn = 1'b1;
    repeat (2 * HP) @(negedge clk);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R9 oe after reset", 32'(mw_sdo_oe), 32'd0);
    check("R9 strobe after reset", 32'(wr_stb), 32'd0);

    for (int v = 0; v < NV; v++) begin
      send_frame(VEC[v][31:16], 16);
      check($sformatf("R6 vector %0d sdo word", v), 32'(got), 32'(VEC[v][15:0]));
      check($sformatf("R3 vector %0d sdo stable while sclk high", v), 32'(stable_ok), 32'd1);
      check($sformatf("R5 vector %0d oe in frame", v), 32'(oe_in_frame), 32'd1);
      if (v == 0) begin
        check("R2 strobe address", 32'(last_a), 32'h03);
        check("R2 strobe data", 32'(last_d), 32'h5A);
        check("R2 single strobe", 32'(n_stb), 32'd1);
      end
    end
    check("R5 oe released after frame", 32'(mw_sdo_oe), 32'd0);
    check("R8 strobes only for in-range writes", 32'(n_stb), 32'd4);

    // R7: short write to reg 1 is discarded
    send_frame({7'h01, 1'b1, 8'h00}, 9);
    check("R7 no strobe on short frame", 32'(n_stb), 32'd4);
    // R10: next full frame decodes from its own first bit; echo skips the short frame
    send_frame({7'h05, 1'b0, 8'h00}, 16);
    check("R7 short frame not echoed, reg1 kept", 32'(got), 32'h0281);
    send_frame({7'h05, 1'b0, 8'h00}, 16);
    check("R10 realigned read of reg 5", 32'(got), 32'h0A00);
    // R7: overlong frame also discarded
    send_frame({7'h05, 1'b1, 8'h77, 1'b1}, 17);
    send_frame({7'h05, 1'b0, 8'h00}, 16);
    check("R7 overlong frame discarded", 32'(got), 32'h0A00);
    check("R7 no strobe on overlong frame", 32'(n_stb), 32'd4);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule